// File: doc/BRIEF.md
# Interrupt Link Router

The block connects eight interrupt link lines to a sixteen-line legacy IRQ bus. Every link has a small routing register: a disable flag and a four-bit target IRQ number. Software reads and writes these registers through a narrow register port that selects a link by number, from 1 to 8. Each link collects level requests from up to eight attached devices. The link counts as active while any of those requests is high.

An active link drives its target IRQ only when its register holds a usable routing. A usable routing has the flag clear and names one of the permitted IRQ lines. Any number of links may target the same IRQ line, and their contributions are ORed. The IRQ bus is registered. If a register is rewritten while its link is active, the assertion moves from the old line to the new one in a single update.

Top module: `irq_link_router`

## Requirements
- R1: After reset every routing register reads 0x80 (disabled) and `irq_out` is all zero.
- R2: Link numbers 1 to 8 on `cfg_link` select a register. `cfg_rdata` shows it in the same cycle. Bit 7 is the disable flag and bits 3:0 are the IRQ number. Bits 6:4 are dropped on write and read as zero.
- R3: Link numbers 0 and 9 to 15 select nothing. Writes to them change no register, and reads return 0x00.
- R4: A routing drives an IRQ only if bit 7 is clear and the IRQ number has its bit set in the permitted mask 0xDEF8. The permitted lines are 3 to 7, 9 to 12, 14 and 15. Any other number drives nothing, exactly as if the link were disabled.
- R5: Link n owns requests `link_req[(n-1)*8 +: 8]` and is active while any of them is high. Its IRQ rises with the first request and falls only after the last request drops.
- R6: `irq_out` is registered. A request change shows on it one clock edge later. A register write is taken at one edge and shows on `irq_out` at the next edge.
- R7: Each `irq_out` bit is the OR over all active links that hold a usable routing to that IRQ number.
- R8: Rewriting the register of an active link moves its contribution from the old IRQ to the new one in the same output update. No cycle shows both lines or neither line driven by the move.
- R9: Writing a register with a value whose stored bits equal the current contents leaves `irq_out` unchanged.
- R10: Setting bit 7 on an active link removes its contribution at once, whatever IRQ number is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_link | input | 4 | Link number, 1 to 8 valid |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected link |
| link_req | input | 64 | Level requests, eight per link |
| irq_out | output | 16 | Legacy IRQ lines |

## Verification
The hardest case to reach is a rewrite that moves a live assertion. The target link must already be active with a usable routing, and the write must land while its requests are held steady. That is the only way to tell an in-place move from a drop followed by a re-raise. The stimulus builds up shared and reserved routings step by step, then rewrites an active link and samples `irq_out` on each of the two following edges. A sweep over all sixteen IRQ numbers on one active link covers the reserved-number cases.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int N_IRQ     = 16;
  localparam int IRQ_IDX_W = $clog2(N_IRQ);
  localparam int DIS_BIT   = 7;

  typedef struct packed {
    logic                 dis;
    logic [IRQ_IDX_W-1:0] irq;
  } route_t;

  localparam route_t ROUTE_RESET = '{dis: 1'b1, irq: '0};

  function automatic route_t byte_to_route(input logic [7:0] b);
    route_t r;
    r.dis = b[DIS_BIT];
    r.irq = b[IRQ_IDX_W-1:0];
    return r;
  endfunction

  function automatic logic [7:0] route_to_byte(input route_t r);
    logic [7:0] b;
    b = '0;
    b[DIS_BIT] = r.dis;
    b[IRQ_IDX_W-1:0] = r.irq;
    return b;
  endfunction
endpackage

// File: rtl/link_route_reg.sv
module link_route_reg
  import irq_route_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output route_t     route_q
);
  route_t route_d;

  always_comb begin
    route_d = route_q;
    if (wr_en) route_d = byte_to_route(wr_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) route_q <= ROUTE_RESET;
    else        route_q <= route_d;
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(route_q));
endmodule

// File: rtl/link_irq_decode.sv
module link_irq_decode
  import irq_route_pkg::*;
#(
  parameter logic [N_IRQ-1:0] ALLOW_MASK = 16'hDEF8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  route_t           route,
  input  logic             active,
  output logic [N_IRQ-1:0] drive
);
  logic usable;

  always_comb begin
    usable = !route.dis && ALLOW_MASK[route.irq];
    drive  = '0;
    if (usable && active) drive[route.irq] = 1'b1;
  end

  // R10
  disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    route.dis |-> (drive == '0));
endmodule

// File: rtl/irq_merge.sv
module irq_merge
  import irq_route_pkg::*;
#(
  parameter int N_LINKS = 8
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_LINKS*N_IRQ-1:0] drive_flat,
  output logic [N_IRQ-1:0]         irq_q
);
  logic [N_IRQ-1:0] irq_d;

  always_comb begin
    irq_d = '0;
    for (int i = 0; i < N_LINKS; i++) irq_d |= drive_flat[i*N_IRQ +: N_IRQ];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/irq_link_router.sv
module irq_link_router
  import irq_route_pkg::*;
#(
  parameter int               N_LINKS      = 8,
  parameter int               REQ_PER_LINK = 8,
  parameter logic [N_IRQ-1:0] ALLOW_MASK   = 16'hDEF8
)(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [$clog2(N_LINKS+1)-1:0]    cfg_link,
  input  logic [7:0]                      cfg_wdata,
  output logic [7:0]                      cfg_rdata,
  input  logic [N_LINKS*REQ_PER_LINK-1:0] link_req,
  output logic [N_IRQ-1:0]                irq_out
);
  localparam int LINK_AW = $clog2(N_LINKS + 1);

  logic                     rst_meta, rst_sync_n;
  route_t                   route [N_LINKS];
  logic [N_LINKS-1:0]       wr_sel;
  logic [N_LINKS*N_IRQ-1:0] drive_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < N_LINKS; i++) begin
      wr_sel[i] = cfg_we && (cfg_link == LINK_AW'(i + 1));
      if (cfg_link == LINK_AW'(i + 1)) cfg_rdata = route_to_byte(route[i]);
    end
  end

  for (genvar g = 0; g < N_LINKS; g++) begin : g_link
    logic active;
    assign active = |link_req[g*REQ_PER_LINK +: REQ_PER_LINK];

    link_route_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (wr_sel[g]),
      .wr_data (cfg_wdata),
      .route_q (route[g])
    );

    link_irq_decode #(.ALLOW_MASK(ALLOW_MASK)) u_dec (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .route  (route[g]),
      .active (active),
      .drive  (drive_flat[g*N_IRQ +: N_IRQ])
    );
  end

  irq_merge #(.N_LINKS(N_LINKS)) u_merge (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .drive_flat (drive_flat),
    .irq_q      (irq_out)
  );

  // R4
  only_permitted_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_out & ~ALLOW_MASK) == '0);

  // R5
  idle_links_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (link_req == '0) |=> (irq_out == '0));

  // R3
  stray_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && (cfg_link == '0)) |=> $stable(drive_flat) || !$stable(link_req));
endmodule

// File: tb/irq_link_router_test.sv
module irq_link_router_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] PERMIT = 16'hDEF8;

  typedef struct packed {
    logic        we;
    logic [3:0]  link;
    logic [7:0]  data;
    logic [7:0]  act;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'd1, 8'h05, 8'h01, 16'h0020},
    '{1'b1, 4'd2, 8'h05, 8'h03, 16'h0020},
    '{1'b1, 4'd1, 8'h0A, 8'h03, 16'h0420},
    '{1'b1, 4'd3, 8'h08, 8'h07, 16'h0420},
    '{1'b1, 4'd3, 8'h0E, 8'h07, 16'h4420},
    '{1'b1, 4'd2, 8'h85, 8'h07, 16'h4400},
    '{1'b1, 4'd4, 8'h73, 8'h0F, 16'h4408},
    '{1'b0, 4'd1, 8'h00, 8'h0C, 16'h4008},
    '{1'b1, 4'd5, 8'h0D, 8'h1C, 16'h4008},
    '{1'b1, 4'd8, 8'h0F, 8'h9C, 16'hC008},
    '{1'b1, 4'd0, 8'h07, 8'h9C, 16'hC008},
    '{1'b1, 4'd8, 8'h0F, 8'h9C, 16'hC008},
    '{1'b0, 4'd1, 8'h00, 8'h00, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_link;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic [63:0] link_req;
  logic [15:0] irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_link_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_link(cfg_link),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .link_req(link_req),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] expand(input logic [7:0] act);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) if (act[i]) r[i*8 + (i % 8)] = 1'b1;
    return r;
  endfunction

  task automatic apply(input logic we, input logic [3:0] lk, input logic [7:0] d,
                       input logic [63:0] req);
    @(negedge clk);
    cfg_we = we; cfg_link = lk; cfg_wdata = d; link_req = req;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] lk, input logic [7:0] exp, input string req);
    cfg_link = lk;
    #1;
    check(req, {8'h00, cfg_rdata}, {8'h00, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_link = '0; cfg_wdata = '0; link_req = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset contents and outputs
    for (int l = 1; l <= 8; l++) rd(4'(l), 8'h80, "R1");
    check("R1", irq_out, 16'h0000);

    // table walk: R4 R7 R8 R9 R10 R2 R3
    for (int v = 0; v < NV; v++) begin
      apply(TBL[v].we, TBL[v].link, TBL[v].data, expand(TBL[v].act));
      check($sformatf("R7 vec%0d", v), irq_out, TBL[v].exp);
    end

    // R2 readback, bits 6:4 dropped
    rd(4'd4, 8'h03, "R2");
    rd(4'd2, 8'h85, "R2");
    rd(4'd3, 8'h0E, "R2");
    rd(4'd5, 8'h0D, "R2");
    // R3 out-of-range reads
    rd(4'd0, 8'h00, "R3");
    rd(4'd9, 8'h00, "R3");
    rd(4'd15, 8'h00, "R3");
    apply(1'b1, 4'd9, 8'h06, '0);
    for (int l = 1; l <= 8; l++) begin
      cfg_link = 4'(l); #1;
      checks++;
      if (cfg_rdata == 8'h06) begin
        fails++;
        $display("FAIL R3 got=%h exp=not 06", cfg_rdata);
      end
    end

    // R5 first-on/last-off on link 1 (routed to IRQ 10), R6 one-edge latency
    @(negedge clk) link_req = 64'h0000_0000_0000_0001;
    check("R6 before edge", irq_out, 16'h0000);
    @(negedge clk) check("R6 one edge", irq_out, 16'h0400);
    link_req = 64'h0000_0000_0000_0021;
    @(negedge clk) check("R5 two on", irq_out, 16'h0400);
    link_req = 64'h0000_0000_0000_0020;
    @(negedge clk) check("R5 one left", irq_out, 16'h0400);
    link_req = 64'h0;
    @(negedge clk) check("R5 last off", irq_out, 16'h0000);

    // R8 live move, sampled each edge
    link_req = 64'h0000_0000_0000_0001;
    @(negedge clk) check("R8 pre", irq_out, 16'h0400);
    cfg_we = 1'b1; cfg_link = 4'd1; cfg_wdata = 8'h06;
    @(negedge clk) cfg_we = 1'b0;
    check("R8 edge1", irq_out, 16'h0400);
    @(negedge clk) check("R8 edge2", irq_out, 16'h0040);
    // R9 same value keeps output
    cfg_we = 1'b1; cfg_wdata = 8'h06;
    @(negedge clk) cfg_we = 1'b0;
    check("R9 edge1", irq_out, 16'h0040);
    @(negedge clk) check("R9 edge2", irq_out, 16'h0040);
    // R10 disable flag on active link keeps IRQ number
    apply(1'b1, 4'd1, 8'h86, 64'h1);
    check("R10", irq_out, 16'h0000);
    rd(4'd1, 8'h86, "R10 readback");

    // R4 sweep on link 6 (requester bit 40)
    for (int q = 0; q < 16; q++) begin
      apply(1'b1, 4'd6, 8'(q), 64'h0000_0100_0000_0000);
      check($sformatf("R4 irq%0d", q), irq_out,
            PERMIT[q] ? (16'h1 << q) : 16'h0);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule